// File: doc/BRIEF.md
# Phase-Shifted Multi-Channel PWM Engine

This block drives a bank of PWM lines from a single shared 12-bit counter. The counter runs free and advances once for every `prescale + 1` clocks. Each channel holds a start count and a stop count. The channel output is high while the counter is inside the window between those two counts. Because the window may cross the counter rollover, a pulse can start at any phase in the period. Spreading the start counts across the channels staggers their rising edges. This lowers simultaneous switching while each channel keeps its own duty.

Each channel has two level overrides, forced-high and forced-low. The forced-low override wins when both are set. A global polarity control inverts every line. A global idle control stops the counter and parks every line at its inactive level. The channel settings pass through a shadow stage that is loaded only at a period boundary, so a write in mid-period cannot cut a pulse short. The prescale value is taken only when the engine leaves idle.

Top module: `phase_pwm_engine`

## Requirements
- R1: One period lasts 4096 counter steps. Each line is registered and reflects the counter value one clock late. A channel loaded at the same time as another shows the same window at the same moment.
- R2: The counter advances exactly once every `prescale + 1` clocks. With prescale 2 and a window of start 0 and stop 1, the line is high for 3 clocks in each period of 12288 clocks.
- R3: When start < stop, the line is high for counter values start..stop-1 and low otherwise.
- R4: When start > stop, the line is high from the start count through the rollover and up to stop-1. Start 4095 with stop 0 gives a single high count at 4095.
- R5: The forced-low flag makes the line low (inactive) whatever the other settings are, including a set forced-high flag.
- R6: The forced-high flag, with forced-low clear, makes the line constantly high (active).
- R7: When start equals stop and neither flag is set, the line stays low.
- R8: While `invert_i` is 1, every line shows the complement of its normal level, including the level parked during idle.
- R9: While `sleep_i` is 1, the counter is held at 0 and every line sits at its inactive level, which is 0, or 1 when inverted. After release, counting restarts from 0. During reset every line is 0.
- R10: A channel's start, stop and flag inputs take effect only at the period rollover, or at the release from idle. A change in mid-period leaves the current period unchanged.
- R11: The prescale input is captured when the engine leaves idle. A change while running has no effect until the next idle-to-run transition.
- R12: With channel n given start n*256 and stop (start + duty) mod 4096, each channel keeps the same duty and its rising edge comes 256 counts after that of channel n-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_i | input | 1 | 1 holds the counter at 0 and parks all lines |
| invert_i | input | 1 | 1 inverts every line |
| prescale_i | input | PRE_W | Clock divider; counter steps every prescale+1 clocks |
| on_cnt_i | input | NUM_CH*12 | Start counts; channel n at bits [n*12 +: 12] |
| off_cnt_i | input | NUM_CH*12 | Stop counts; channel n at bits [n*12 +: 12] |
| full_on_i | input | NUM_CH | Forced-high flag per channel |
| full_off_i | input | NUM_CH | Forced-low flag per channel, wins over forced-high |
| pwm_o | output | NUM_CH | PWM lines |

## Verification
Every channel is followed through whole periods against a model built on modular distance from the start count. The windows used are plain, wrapped across the rollover, empty, a single count at either end of the period, and staggered. Together these separate a wrong compare direction, a bad wrap test and an off-by-one at the period ends. Forced flags are tried alone, together, and with inversion, which shows the priority order and the polarity handling. Two directed runs cover the remaining timing rules. In one, the settings and the prescale are changed in mid-period, which exposes a shadow stage or prescale capture that loads too early. In the other, a slow prescale is used, which shows whether the divider counts prescale+1 clocks per step.

// File: rtl/phase_pwm_pkg.sv
package phase_pwm_pkg;

  localparam int unsigned CNT_W = 12;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    cnt_t start_c;
    cnt_t stop_c;
    logic frc_hi;
    logic frc_lo;
  } chan_cfg_t;

  // Level of one channel for counter value k, before polarity.
  function automatic logic pulse_level(chan_cfg_t c, cnt_t k);
    if (c.frc_lo) return 1'b0;
    if (c.frc_hi) return 1'b1;
    if (c.start_c == c.stop_c) return 1'b0;
    if (c.start_c < c.stop_c) return (k >= c.start_c) && (k < c.stop_c);
    return (k >= c.start_c) || (k < c.stop_c);
  endfunction

  function automatic cnt_t next_count(cnt_t k);
    return k + 1'b1;
  endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import phase_pwm_pkg::*;
#(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_i,
  input  logic [PRE_W-1:0] prescale_i,
  output cnt_t             cnt_o,
  output logic             load_o,
  output logic             run_o
);

  logic             pend_q;
  logic             run_q;
  logic [PRE_W-1:0] presc_q;
  logic [PRE_W-1:0] div_q;
  cnt_t             cnt_q;

  // named events
  logic start_w;
  logic tick_w;
  logic wrap_w;

  assign start_w = pend_q & ~sleep_i;
  assign tick_w  = run_q & ~sleep_i & (div_q == presc_q);
  assign wrap_w  = tick_w & (cnt_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b1;
      run_q   <= 1'b0;
      presc_q <= '0;
      div_q   <= '0;
      cnt_q   <= '0;
    end else if (sleep_i) begin
      pend_q  <= 1'b1;
      run_q   <= 1'b0;
      div_q   <= '0;
      cnt_q   <= '0;
    end else if (start_w) begin
      pend_q  <= 1'b0;
      run_q   <= 1'b1;
      presc_q <= prescale_i;
      div_q   <= '0;
      cnt_q   <= '0;
    end else if (run_q) begin
      if (tick_w) begin
        div_q <= '0;
        cnt_q <= next_count(cnt_q);
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign load_o = start_w | wrap_w;
  assign run_o  = run_q;

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_w |=> (cnt_t'(cnt_q - $past(cnt_q)) == cnt_t'(1)));

  p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !sleep_i && !tick_w) |=> $stable(cnt_q));

  p_div_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    div_q <= presc_q);

  p_sleep_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> (cnt_q == '0) && !run_q);

  p_presc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !start_w |=> $stable(presc_q));

endmodule

// File: rtl/pwm_chan_slice.sv
module pwm_chan_slice
  import phase_pwm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load_i,
  input  logic      gate_i,
  input  logic      inv_i,
  input  cnt_t      cnt_i,
  input  chan_cfg_t cfg_i,
  output logic      pwm_o
);

  chan_cfg_t sh_q;
  logic      out_q;
  logic      lvl_w;

  assign lvl_w = pulse_level(sh_q, cnt_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      out_q <= 1'b0;
    end else begin
      if (load_i) sh_q <= cfg_i;
      out_q <= gate_i ? (lvl_w ^ inv_i) : inv_i;
    end
  end

  assign pwm_o = out_q;

  p_frc_lo_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_i && sh_q.frc_lo) |=> (out_q == $past(inv_i)));

  p_frc_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_i && sh_q.frc_hi && !sh_q.frc_lo) |=> (out_q == !$past(inv_i)));

  p_empty_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_i && !sh_q.frc_hi && !sh_q.frc_lo && (sh_q.start_c == sh_q.stop_c))
      |=> (out_q == $past(inv_i)));

  p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_i |=> (out_q == $past(inv_i)));

  p_shadow_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(sh_q));

endmodule

// File: rtl/phase_pwm_engine.sv
module phase_pwm_engine
  import phase_pwm_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned PRE_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sleep_i,
  input  logic                    invert_i,
  input  logic [PRE_W-1:0]        prescale_i,
  input  logic [NUM_CH*CNT_W-1:0] on_cnt_i,
  input  logic [NUM_CH*CNT_W-1:0] off_cnt_i,
  input  logic [NUM_CH-1:0]       full_on_i,
  input  logic [NUM_CH-1:0]       full_off_i,
  output logic [NUM_CH-1:0]       pwm_o
);

  cnt_t cnt_w;
  logic load_w;
  logic run_w;
  logic gate_w;

  pwm_timebase #(.PRE_W(PRE_W)) u_tb (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_i    (sleep_i),
    .prescale_i (prescale_i),
    .cnt_o      (cnt_w),
    .load_o     (load_w),
    .run_o      (run_w)
  );

  assign gate_w = run_w & ~sleep_i;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    chan_cfg_t cfg_w;
    assign cfg_w.start_c = on_cnt_i[n*CNT_W +: CNT_W];
    assign cfg_w.stop_c  = off_cnt_i[n*CNT_W +: CNT_W];
    assign cfg_w.frc_hi  = full_on_i[n];
    assign cfg_w.frc_lo  = full_off_i[n];

    pwm_chan_slice u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load_w),
      .gate_i (gate_w),
      .inv_i  (invert_i),
      .cnt_i  (cnt_w),
      .cfg_i  (cfg_w),
      .pwm_o  (pwm_o[n])
    );
  end

  p_sleep_parks_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> (pwm_o == {NUM_CH{$past(invert_i)}}));

endmodule

// File: tb/phase_pwm_engine_tb.sv
module phase_pwm_engine_tb;

  localparam int NCH = 16;
  localparam int CW = 12;
  localparam int PER = 4096;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG_CYC = 150000;

  localparam int ROWS = 10;
  localparam int R_ON [ROWS] = '{0, 3000, 4095, 100, 0, 50, 0, 0, 0, 10};
  localparam int R_OFF[ROWS] = '{2048, 500, 0, 100, 0, 60, 1024, 1000, 4095, 20};
  localparam bit R_FHI[ROWS] = '{0, 0, 0, 0, 1, 1, 0, 0, 0, 0};
  localparam bit R_FLO[ROWS] = '{0, 0, 0, 0, 0, 1, 0, 0, 0, 1};
  localparam bit R_INV[ROWS] = '{0, 0, 0, 0, 0, 0, 1, 0, 0, 1};
  localparam bit R_STG[ROWS] = '{0, 0, 0, 0, 0, 0, 0, 1, 0, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_i = 1'b1;
  logic invert_i = 1'b0;
  logic [7:0] prescale_i = '0;
  logic [NCH*CW-1:0] on_cnt_i = '0;
  logic [NCH*CW-1:0] off_cnt_i = '0;
  logic [NCH-1:0] full_on_i = '0;
  logic [NCH-1:0] full_off_i = '0;
  logic [NCH-1:0] pwm_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  int d_on[NCH], d_off[NCH];
  bit d_hi[NCH], d_lo[NCH];
  int e_on[NCH], e_off[NCH];
  bit e_hi[NCH], e_lo[NCH];

  phase_pwm_engine u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .invert_i(invert_i),
    .prescale_i(prescale_i), .on_cnt_i(on_cnt_i), .off_cnt_i(off_cnt_i),
    .full_on_i(full_on_i), .full_off_i(full_off_i), .pwm_o(pwm_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG_CYC) begin
        checks++;
        failures++;
        $display("FAIL watchdog expired act=%0d exp<=%0d", cyc, WATCHDOG_CYC);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  // Expected level from modular distance to the start count.
  function automatic bit exp_level(int on, int off, bit hi, bit lo, int k);
    int span, pos;
    if (lo) return 1'b0;
    if (hi) return 1'b1;
    span = (off - on + PER) % PER;
    pos  = (k - on + PER) % PER;
    return pos < span;
  endfunction

  function automatic string row_tag(int r);
    case (r)
      0: return "R3 plain window";
      1: return "R4 wrapped window";
      2: return "R4 single count at 4095";
      3: return "R7 empty window";
      4: return "R6 forced high";
      5: return "R5 forced low beats forced high";
      6: return "R8 inverted window";
      7: return "R12 staggered starts";
      8: return "R3 window to 4094";
      default: return "R5 R8 forced low inverted";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_cfg();
    for (int c = 0; c < NCH; c++) begin
      on_cnt_i[c*CW +: CW]  = CW'(d_on[c]);
      off_cnt_i[c*CW +: CW] = CW'(d_off[c]);
      full_on_i[c]  = d_hi[c];
      full_off_i[c] = d_lo[c];
    end
  endtask

  task automatic latch_expect();
    for (int c = 0; c < NCH; c++) begin
      e_on[c] = d_on[c]; e_off[c] = d_off[c];
      e_hi[c] = d_hi[c]; e_lo[c] = d_lo[c];
    end
  endtask

  task automatic set_all(int on, int off, bit hi, bit lo);
    for (int c = 0; c < NCH; c++) begin
      d_on[c] = on; d_off[c] = off; d_hi[c] = hi; d_lo[c] = lo;
    end
  endtask

  // Samples n negedges; sample j shows counter value (k0+j) mod 4096 (prescale 0).
  task automatic run_window(input int k0, input int n, input string tag);
    int bad = 0;
    logic [NCH-1:0] fa = '0, fe = '0;
    for (int j = 0; j < n; j++) begin
      logic [NCH-1:0] ev;
      @(negedge clk);
      for (int c = 0; c < NCH; c++)
        ev[c] = exp_level(e_on[c], e_off[c], e_hi[c], e_lo[c], (k0 + j) % PER) ^ invert_i;
      if (pwm_o !== ev) begin
        if (bad == 0) begin fa = pwm_o; fe = ev; end
        bad++;
      end
    end
    check(bad == 0, tag, fa, fe);
  endtask

  // Sleep for one edge, then release; returns at negedge N1 (first sample follows).
  task automatic restart(input string tag);
    @(negedge clk);
    sleep_i = 1'b1;
    @(negedge clk);
    check(pwm_o === {NCH{invert_i}}, tag, pwm_o, {NCH{invert_i}});
    drive_cfg();
    latch_expect();
    sleep_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int hi_cnt;
    bit lvl;
    set_all(0, 0, 0, 0);
    drive_cfg();
    #(CLK_PERIOD*3);
    check(pwm_o === '0, "R9 reset level", pwm_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(pwm_o === '0, "R9 idle level", pwm_o, 0);
    invert_i = 1'b1;
    repeat (2) @(negedge clk);
    check(pwm_o === '1, "R8 idle level inverted", pwm_o, {NCH{1'b1}});

    // table walk
    for (int r = 0; r < ROWS; r++) begin
      invert_i = R_INV[r];
      for (int c = 0; c < NCH; c++) begin
        d_on[c]  = R_STG[r] ? c * (PER / NCH) : R_ON[r];
        d_off[c] = R_STG[r] ? (c * (PER / NCH) + R_OFF[r]) % PER : R_OFF[r];
        d_hi[c]  = R_FHI[r];
        d_lo[c]  = R_FLO[r];
      end
      restart("R9 parked while idle");
      run_window(0, PER, row_tag(r));
    end

    // R10: mid-period change held until rollover; R1: rollover after 4096 steps
    invert_i = 1'b0;
    set_all(0, 2048, 0, 0);
    restart("R9 parked before shadow test");
    run_window(0, 1000, "R10 first part");
    set_all(1024, 3072, 0, 0);
    d_hi[3] = 1'b1;
    drive_cfg();
    run_window(1000, PER - 1000, "R10 old settings kept to period end");
    latch_expect();
    run_window(0, PER, "R1 R10 new settings after rollover");

    // R2/R11: prescale 2, change while running ignored
    set_all(0, 1, 0, 0);
    prescale_i = 8'd2;
    restart("R9 parked before prescale test");
    hi_cnt = 0;
    for (int j = 0; j < 3*PER + 4; j++) begin
      @(negedge clk);
      lvl = pwm_o[0];
      if (j == 5) prescale_i = 8'd0;
      if (j < 3*PER && lvl) hi_cnt++;
      if (j == 2) check(lvl === 1'b1, "R2 high through third clock", lvl, 1);
      if (j == 3*PER) check(lvl === 1'b1, "R11 next period at 12288", lvl, 1);
      if (j == 3*PER + 3) check(lvl === 1'b0, "R11 period length kept", lvl, 0);
    end
    check(hi_cnt == 3, "R2 three clocks per count", hi_cnt, 3);
    restart("R9 parked before recapture");
    run_window(0, PER, "R11 prescale recaptured at wake");

    // R9: sleep in mid-run parks even a forced-high line, then restarts at 0
    set_all(0, 200, 1, 0);
    drive_cfg();
    @(negedge clk);
    sleep_i = 1'b1;
    @(negedge clk);
    check(pwm_o === '0, "R9 sleep parks running lines", pwm_o, 0);
    set_all(0, 200, 0, 0);
    drive_cfg();
    latch_expect();
    sleep_i = 1'b0;
    @(negedge clk);
    run_window(0, 300, "R9 count restarts from zero");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule